// File: doc/BRIEF.md
# Deferred Program-Bank Select Unit

This unit sits next to the opcode decoder and program counter of a small 8-bit controller that addresses 4 KB of program memory. That space is split into a lower half (0x000–0x7FF) and an upper half (0x800–0xFFF). Two opcodes choose which half the next branch lands in. They do not change the running address. The unit keeps a pending bank bit. When a jump or call loads a new 11-bit target, the unit joins that bit to the target to form the 12-bit program counter value.

A third opcode turns on a helper that gates an address line. Once set, this enable stays on until reset, and no opcode can clear it. The unit never stalls its neighbours. The opcode strobe and the load strobe are accepted in every cycle, so the block applies no back-pressure and has no ready signals.

Top module: `pbank_unit`

## Requirements
- R1: Reset (rst_n low) clears pc_out to 0x000, clears gate_en, and clears the pending bank, so the first load after reset lands in the lower half.
- R2: An accepted opcode 0x63 (op_valid high) makes every later load set pc_out[11] to 0.
- R3: An accepted opcode 0x73 makes every later load set pc_out[11] to 1. The bit persists across loads until another bank opcode arrives.
- R4: On a cycle with jmp_load high, pc_out becomes {pending bank, jmp_target[10:0]} one clock later. Without jmp_load, pc_out holds its value.
- R5: A bank-select opcode leaves pc_out unchanged on its own.
- R6: Of several bank-select opcodes accepted before a load, the last one decides the bank.
- R7: When a bank-select opcode and jmp_load fall in the same cycle, the load uses the bank as it stood before that cycle, and the new choice applies from the following load.
- R8: An accepted opcode 0x33 sets gate_en one clock later. gate_en then stays high until reset.
- R9: Opcodes other than 0x63, 0x73 and 0x33, and any opcode presented with op_valid low, change neither the pending bank nor gate_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Qualifies op_byte as a fetched opcode |
| op_byte | input | 8 | Fetched opcode |
| jmp_load | input | 1 | A jump or call loads its target this cycle |
| jmp_target | input | 11 | In-bank branch target |
| pc_out | output | 12 | Program counter value formed at the last load |
| gate_en | output | 1 | Sticky address-gate helper enable |

## Verification
The bound checker watches these properties in every cycle:
- The low eleven bits of a load follow the target.
- pc_out holds between loads.
- Bit 11 of a load matches the internal pending bank.
- Each bank opcode drives the pending bank to its value.
- gate_en rises only after its opcode and never falls.

The scenarios alone show how the bank choice behaves over time, as seen from the ports:
- The deferred effect of a bank select.
- The last-wins rule.
- The same-cycle ordering against a load.
- That ignored opcodes leave the branch bank untouched.
- That reset clears a set enable.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
  localparam int unsigned OP_W      = 8;
  localparam int unsigned PC_W      = 12;
  localparam int unsigned OFS_W     = PC_W - 1;
  localparam logic [OP_W-1:0] OP_BANK_LO = 8'h63;
  localparam logic [OP_W-1:0] OP_BANK_HI = 8'h73;
  localparam logic [OP_W-1:0] OP_GATE_ON = 8'h33;

  typedef struct packed {
    logic pick_lo;
    logic pick_hi;
    logic gate_set;
  } dec_t;
endpackage

// File: rtl/pbank_decode.sv
module pbank_decode
  import pbank_pkg::*;
(
  input  logic            valid,
  input  logic [OP_W-1:0] op,
  output dec_t            dec
);
  always_comb begin
    dec.pick_lo  = valid && (op == OP_BANK_LO);
    dec.pick_hi  = valid && (op == OP_BANK_HI);
    dec.gate_set = valid && (op == OP_GATE_ON);
  end
endmodule

// File: rtl/pbank_state.sv
module pbank_state
  import pbank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  dec_t dec,
  output logic bank_q,
  output logic gate_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      if (dec.pick_hi)      bank_q <= 1'b1;
      else if (dec.pick_lo) bank_q <= 1'b0;
      if (dec.gate_set)     gate_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pbank_pcform.sv
module pbank_pcform
  import pbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             bank,
  input  logic [OFS_W-1:0] target,
  output logic [PC_W-1:0]  pc
);
  always_ff @(posedge clk) begin
    if (!rst_n)    pc <= '0;
    else if (load) pc <= {bank, target};
  end
endmodule

// File: rtl/pbank_unit.sv
module pbank_unit
  import pbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_byte,
  input  logic             jmp_load,
  input  logic [OFS_W-1:0] jmp_target,
  output logic [PC_W-1:0]  pc_out,
  output logic             gate_en
);
  dec_t dec;
  logic bank_q;

  pbank_decode u_dec (.valid(op_valid), .op(op_byte), .dec(dec));

  pbank_state u_st (
    .clk(clk), .rst_n(rst_n), .dec(dec),
    .bank_q(bank_q), .gate_q(gate_en)
  );

  pbank_pcform u_pc (
    .clk(clk), .rst_n(rst_n), .load(jmp_load), .bank(bank_q),
    .target(jmp_target), .pc(pc_out)
  );
endmodule

// File: rtl/pbank_unit_chk.sv
module pbank_unit_chk
  import pbank_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [OP_W-1:0]  op_byte,
  input logic             jmp_load,
  input logic [OFS_W-1:0] jmp_target,
  input logic [PC_W-1:0]  pc_out,
  input logic             gate_en,
  input logic             bank_q
);
  // R4
  target_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_load |=> pc_out[OFS_W-1:0] == $past(jmp_target));
  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !jmp_load |=> $stable(pc_out));
  // R7
  bank_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_load |=> pc_out[PC_W-1] == $past(bank_q));
  // R2
  bank_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_byte == OP_BANK_LO) |=> !bank_q);
  // R3
  bank_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_byte == OP_BANK_HI) |=> bank_q);
  // R8
  gate_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_byte == OP_GATE_ON) |=> gate_en);
  // R8
  gate_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |=> gate_en);
  // R9
  gate_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(op_valid && op_byte == OP_GATE_ON));
endmodule

bind pbank_unit pbank_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
  .jmp_load(jmp_load), .jmp_target(jmp_target), .pc_out(pc_out),
  .gate_en(gate_en), .bank_q(bank_q)
);

// File: tb/pbank_unit_tb.sv
`timescale 1ns/1ps
module pbank_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = 8'h00;
  logic        jmp_load = 1'b0;
  logic [10:0] jmp_target = '0;
  logic [11:0] pc_out;
  logic        gate_en;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pbank_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .jmp_load(jmp_load), .jmp_target(jmp_target),
    .pc_out(pc_out), .gate_en(gate_en)
  );

  typedef struct packed {
    logic        ov;
    logic [7:0]  op;
    logic        jl;
    logic [10:0] tg;
    logic [11:0] pc;
    logic        ge;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{1'b0, 8'h00, 1'b1, 11'h123, 12'h123, 1'b0, 8'd1}, // R1 bank 0 after reset
    '{1'b1, 8'h73, 1'b0, 11'h000, 12'h123, 1'b0, 8'd5}, // R5 select alone
    '{1'b0, 8'h00, 1'b1, 11'h045, 12'h845, 1'b0, 8'd3}, // R3
    '{1'b0, 8'h00, 1'b1, 11'h7FF, 12'hFFF, 1'b0, 8'd3}, // R3 persists
    '{1'b1, 8'h63, 1'b0, 11'h000, 12'hFFF, 1'b0, 8'd5}, // R5
    '{1'b0, 8'h00, 1'b1, 11'h001, 12'h001, 1'b0, 8'd2}, // R2
    '{1'b1, 8'h73, 1'b0, 11'h000, 12'h001, 1'b0, 8'd6}, // R6 first select
    '{1'b1, 8'h63, 1'b0, 11'h000, 12'h001, 1'b0, 8'd6}, // R6 second select
    '{1'b0, 8'h00, 1'b1, 11'h2AA, 12'h2AA, 1'b0, 8'd6}, // R6 last wins
    '{1'b1, 8'h73, 1'b1, 11'h100, 12'h100, 1'b0, 8'd7}, // R7 same cycle
    '{1'b0, 8'h00, 1'b1, 11'h100, 12'h900, 1'b0, 8'd7}, // R7 next load
    '{1'b1, 8'h33, 1'b0, 11'h000, 12'h900, 1'b1, 8'd8}, // R8 set
    '{1'b1, 8'hA5, 1'b0, 11'h000, 12'h900, 1'b1, 8'd8}, // R8 sticky
    '{1'b0, 8'h63, 1'b1, 11'h0AB, 12'h8AB, 1'b1, 8'd9}, // R9 valid low
    '{1'b1, 8'h62, 1'b1, 11'h0CD, 12'h8CD, 1'b1, 8'd9}  // R9 other opcode
  };

  task automatic check(input int req, input logic [11:0] pc_exp, input logic ge_exp);
    n_chk++;
    if (pc_out !== pc_exp || gate_en !== ge_exp) begin
      n_fail++;
      $display("FAIL R%0d: pc_out=%h gate_en=%b expected pc_out=%h gate_en=%b",
               req, pc_out, gate_en, pc_exp, ge_exp);
    end
  endtask

  task automatic step(input logic ov, input logic [7:0] op,
                      input logic jl, input logic [10:0] tg);
    op_valid = ov; op_byte = op; jmp_load = jl; jmp_target = tg;
    @(negedge clk);
    op_valid = 1'b0; jmp_load = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 12'h000, 1'b0); // R1 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VT[i].ov, VT[i].op, VT[i].jl, VT[i].tg);
      check(int'(VT[i].req), VT[i].pc, VT[i].ge);
    end
    // R1: reset clears enable, pc and pending bank (currently 1)
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 12'h000, 1'b0);
    rst_n = 1'b1;
    step(1'b0, 8'h00, 1'b1, 11'h555);
    check(1, 12'h555, 1'b0); // R1 bank back to 0
    // R9: gate opcode with valid low is ignored
    step(1'b0, 8'h33, 1'b0, 11'h000);
    check(9, 12'h555, 1'b0);
    // R8: set then many other opcodes
    step(1'b1, 8'h33, 1'b0, 11'h000);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 8'(8'h63 + 8'(k * 16)), 1'b0, 11'h000);
      check(8, 12'h555, 1'b1);
    end
    // last of those was 0x93: no bank change, bank still 1 from 0x73 (k=1)
    step(1'b0, 8'h00, 1'b1, 11'h00F);
    check(3, 12'h80F, 1'b1); // R3
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule